// File: doc/BRIEF.md
# Delay Line Calibration Controller

This block finds how many unit buffer delays make up one system clock period. The clock comes from a compensated PLL, so its period serves as a fixed time reference. The block drives a tap select into a measurement delay line and reads back a one-bit comparator flag. The flag is high once the selected chain is at least one clock period long. The first tap at which the flag is seen high is the calibration count. That count then goes to every programmable delay line in a single-cycle load strobe, so the delay lines can be set in units of time.

Four events start a calibration:
- the release of reset;
- a self-refresh exit request;
- a software request;
- the expiry of an optional periodic timer.

A self-refresh exit is acknowledged only in the cycle the fresh count is loaded. If the flag never goes high, the sweep stops at the last tap and an overflow status bit is set.

Top module: `dlcal_ctrl`

## Requirements
- R1: In the first clock cycle after reset is released, a calibration starts without any request, so `busy` is high after that first edge.
- R2: While a calibration sweeps, `tap_sel` counts up from 1 in steps of one. Each value is held for exactly 2 clock cycles. `tap_sel` is 0 whenever no sweep is running, including the load cycle.
- R3: The comparator flag is sampled in the second cycle of each tap's hold. The count is the first tap value at which the sampled flag is 1.
- R4: If the flag is still 0 when tap 255 is sampled, the count is 255 and `overflow` is 1. Any calibration that finds the flag high clears `overflow`. `overflow` changes only when a count is loaded.
- R5: The cycle after the final sample, `pdl_load` is high for exactly one cycle. During that cycle `pdl_value` carries the count, and `pdl_value` keeps that count until the next load.
- R6: `busy` is high from the cycle after a calibration is started up to and including the load cycle. It is low otherwise.
- R7: A pulse on `sr_exit_req` makes `sr_exit_ack` pulse in the load cycle of the next calibration that starts after the request. `sr_exit_ack` is never high outside such a load cycle.
- R8: A pulse on `sw_cal_req` starts a calibration while the block is idle. A pulse that arrives while the block is busy is held, and it causes exactly one further calibration afterwards.
- R9: While `periodic_en` is high, an internal cycle counter expires every `periodic_interval` cycles (a value of 0 acts as 1). An expiry while the block is idle starts a calibration. An expiry while the block is busy, or in the cycle a calibration is started, is absorbed into that calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the timing reference |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_cal_req | input | 1 | One-cycle software recalibration request |
| sr_exit_req | input | 1 | One-cycle self-refresh exit request |
| periodic_en | input | 1 | Enables the periodic recalibration timer |
| periodic_interval | input | 16 | Timer period in clock cycles |
| cmp_reached | input | 1 | Comparator flag from the measurement chain |
| tap_sel | output | 8 | Tap select to the measurement chain |
| pdl_load | output | 1 | One-cycle load strobe to the delay lines |
| pdl_value | output | 8 | Calibration count for the delay lines |
| busy | output | 1 | Calibration in progress |
| overflow | output | 1 | Last sweep ended without the flag setting |
| sr_exit_ack | output | 1 | Self-refresh exit acknowledge |

## Verification
The bound checker watches, on every cycle, the properties that are local in time:
- the load strobe lasts one cycle and only ever occurs while busy;
- the acknowledge coincides with a load;
- the tap select is zero when idle and climbs only one step at a time;
- the overflow bit rises only on a saturated load of 255.

Other behaviour can only be shown by the bench's scenarios, which run a cycle-by-cycle model against a modelled delay chain:
- the count found for a given chain length, including the boundary taps 1 and 255 and a chain that never reaches a period;
- the two-cycle dwell on each tap;
- a software request queued during a sweep;
- an acknowledge that belongs to the calibration started after the exit request;
- timer expiries absorbed into a running calibration.

// File: rtl/dlcal_pkg.sv
package dlcal_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE  = 2'd0,
    CAL_SWEEP = 2'd1,
    CAL_LOAD  = 2'd2
  } cal_state_t;

  // last cycle of a tap's hold window
  function automatic logic hold_over(input int unsigned dwell, input int unsigned settle);
    return dwell == settle - 1;
  endfunction

  // sweep ends on a hit or on the last tap
  function automatic logic sweep_end(input logic hit, input int unsigned tap, input int unsigned tap_max);
    return hit || (tap == tap_max);
  endfunction

  // timer expires when the next count reaches the interval (0 behaves as 1)
  function automatic logic tick_expire(input int unsigned cnt, input int unsigned interval);
    return (cnt + 1) >= interval;
  endfunction

endpackage

// File: rtl/dlcal_trigger.sv
module dlcal_trigger #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_req,
  input  logic               sr_req,
  input  logic               per_en,
  input  logic [TIMER_W-1:0] per_interval,
  input  logic               idle,
  input  logic               take,
  output logic               pend_any,
  output logic               sr_pend,
  output logic               timer_fire
);
  import dlcal_pkg::*;

  logic               boot_q;
  logic               sw_q;
  logic               sr_q;
  logic               tmr_q;
  logic [TIMER_W-1:0] tcnt;

  assign timer_fire = per_en && tick_expire(int'(tcnt), int'(per_interval));
  assign pend_any   = boot_q | sw_q | sr_q | tmr_q;
  assign sr_pend    = sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      sw_q   <= 1'b0;
      sr_q   <= 1'b0;
      tmr_q  <= 1'b0;
      tcnt   <= '0;
    end else begin
      boot_q <= boot_q & ~take;
      sw_q   <= (sw_q & ~take) | sw_req;
      sr_q   <= (sr_q & ~take) | sr_req;
      // expiries while busy or while starting are merged
      tmr_q  <= (tmr_q & ~take) | (timer_fire & idle & ~take);
      if (!per_en || timer_fire) tcnt <= '0;
      else                       tcnt <= tcnt + 1'b1;
    end
  end

endmodule

// File: rtl/dlcal_sweep.sv
module dlcal_sweep #(
  parameter int TAP_W  = 8,
  parameter int SETTLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sr_tag_in,
  input  logic             cmp,
  output logic             busy,
  output logic [TAP_W-1:0] tap_sel,
  output logic             load,
  output logic [TAP_W-1:0] value,
  output logic             ovf,
  output logic             ack,
  output logic             done
);
  import dlcal_pkg::*;

  localparam int TAP_MAX = (1 << TAP_W) - 1;
  localparam int DWELL_W = $clog2(SETTLE + 1);

  cal_state_t       state;
  logic [TAP_W-1:0] tap;
  logic [DWELL_W-1:0] dwell;
  logic [TAP_W-1:0] result;
  logic             ovf_q;
  logic             sr_tag;
  logic             sample;

  assign sample  = (state == CAL_SWEEP) && hold_over(int'(dwell), SETTLE);
  assign done    = sample && sweep_end(cmp, int'(tap), TAP_MAX);
  assign busy    = (state != CAL_IDLE);
  assign load    = (state == CAL_LOAD);
  assign ack     = load & sr_tag;
  assign tap_sel = tap;
  assign value   = result;
  assign ovf     = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= CAL_IDLE;
      tap    <= '0;
      dwell  <= '0;
      result <= '0;
      ovf_q  <= 1'b0;
      sr_tag <= 1'b0;
    end else begin
      unique case (state)
        CAL_IDLE: begin
          if (start) begin
            state  <= CAL_SWEEP;
            tap    <= TAP_W'(1);
            dwell  <= '0;
            sr_tag <= sr_tag_in;
          end
        end
        CAL_SWEEP: begin
          if (done) begin
            state  <= CAL_LOAD;
            result <= tap;
            ovf_q  <= ~cmp;
            tap    <= '0;
          end else if (sample) begin
            tap   <= tap + 1'b1;
            dwell <= '0;
          end else begin
            dwell <= dwell + 1'b1;
          end
        end
        CAL_LOAD: begin
          state  <= CAL_IDLE;
          sr_tag <= 1'b0;
        end
        default: state <= CAL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dlcal_ctrl.sv
module dlcal_ctrl #(
  parameter int TAP_W   = 8,
  parameter int SETTLE  = 2,
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_cal_req,
  input  logic               sr_exit_req,
  input  logic               periodic_en,
  input  logic [TIMER_W-1:0] periodic_interval,
  input  logic               cmp_reached,
  output logic [TAP_W-1:0]   tap_sel,
  output logic               pdl_load,
  output logic [TAP_W-1:0]   pdl_value,
  output logic               busy,
  output logic               overflow,
  output logic               sr_exit_ack
);

  logic pend_any;
  logic sr_pend;
  logic timer_fire;
  logic cal_start;
  logic sweep_done;

  assign cal_start = ~busy & pend_any;

  dlcal_trigger #(.TIMER_W(TIMER_W)) u_trig (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_req       (sw_cal_req),
    .sr_req       (sr_exit_req),
    .per_en       (periodic_en),
    .per_interval (periodic_interval),
    .idle         (~busy),
    .take         (cal_start),
    .pend_any     (pend_any),
    .sr_pend      (sr_pend),
    .timer_fire   (timer_fire)
  );

  dlcal_sweep #(.TAP_W(TAP_W), .SETTLE(SETTLE)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cal_start),
    .sr_tag_in (sr_pend),
    .cmp       (cmp_reached),
    .busy      (busy),
    .tap_sel   (tap_sel),
    .load      (pdl_load),
    .value     (pdl_value),
    .ovf       (overflow),
    .ack       (sr_exit_ack),
    .done      (sweep_done)
  );

endmodule

// File: rtl/dlcal_chk.sv
module dlcal_chk #(
  parameter int TAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TAP_W-1:0] tap_sel,
  input logic             pdl_load,
  input logic [TAP_W-1:0] pdl_value,
  input logic             busy,
  input logic             overflow,
  input logic             sr_exit_ack,
  input logic             cal_start,
  input logic             sweep_done
);
  localparam logic [TAP_W-1:0] TOP_TAP = '1;

  // R5
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdl_load |=> !pdl_load);

  // R5
  load_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> pdl_load);

  // R6
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdl_load |-> busy);

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> busy);

  // R7
  ack_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_ack |-> pdl_load);

  // R2
  idle_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tap_sel == '0));

  // R2
  tap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tap_sel != '0) |=> (tap_sel == '0 || tap_sel == $past(tap_sel) || tap_sel == $past(tap_sel) + 1'b1));

  // R4
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> (pdl_load && pdl_value == TOP_TAP));

endmodule

bind dlcal_ctrl dlcal_chk #(.TAP_W(TAP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tap_sel     (tap_sel),
  .pdl_load    (pdl_load),
  .pdl_value   (pdl_value),
  .busy        (busy),
  .overflow    (overflow),
  .sr_exit_ack (sr_exit_ack),
  .cal_start   (cal_start),
  .sweep_done  (sweep_done)
);

// File: tb/dlcal_ctrl_tb.sv
module dlcal_ctrl_tb;
  localparam int HOLD = 2;
  localparam int LAST = 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_cal_req = 1'b0;
  logic        sr_exit_req = 1'b0;
  logic        periodic_en = 1'b0;
  logic [15:0] periodic_interval = 16'd0;
  logic        cmp_reached;
  logic [7:0]  tap_sel;
  logic        pdl_load;
  logic [7:0]  pdl_value;
  logic        busy;
  logic        overflow;
  logic        sr_exit_ack;

  int target = 10;   // chain length in taps that equals one period
  int checks = 0;
  int fails  = 0;
  int loads_seen = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  // modelled analog chain
  assign cmp_reached = (tap_sel != 8'd0) && (int'(tap_sel) >= target);

  dlcal_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sw_cal_req(sw_cal_req), .sr_exit_req(sr_exit_req),
    .periodic_en(periodic_en), .periodic_interval(periodic_interval),
    .cmp_reached(cmp_reached), .tap_sel(tap_sel), .pdl_load(pdl_load),
    .pdl_value(pdl_value), .busy(busy), .overflow(overflow), .sr_exit_ack(sr_exit_ack)
  );

  // behavioural reference: phase 0 idle, 1 sweep, 2 load; e = cycles spent sweeping
  int ph = 0, e = 0, res = 0, ov = 0, tag = 0, tcnt = 0;
  bit q_boot = 1, q_sw = 0, q_sr = 0, q_tm = 0;

  function automatic int m_tap();
    return (ph == 1) ? (e / HOLD + 1) : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; e = 0; res = 0; ov = 0; tag = 0; tcnt = 0;
      q_boot = 1; q_sw = 0; q_sr = 0; q_tm = 0;
    end else begin
      bit fire, go, hit;
      int t;
      fire = periodic_en && (tcnt + 1 >= int'(periodic_interval));
      go   = (ph == 0) && (q_boot || q_sw || q_sr || q_tm);
      t    = m_tap();
      hit  = (t >= target);
      tcnt = (!periodic_en || fire) ? 0 : tcnt + 1;
      case (ph)
        0: if (go) begin ph = 1; e = 0; tag = q_sr; end
        1: if ((e % HOLD) == HOLD - 1 && (hit || t == LAST)) begin
             ph = 2; res = t; ov = hit ? 0 : 1;
           end else e = e + 1;
        default: begin ph = 0; tag = 0; end
      endcase
      if (go) begin q_boot = 0; q_sw = 0; q_sr = 0; q_tm = 0; end
      if (sw_cal_req) q_sw = 1;
      if (sr_exit_req) q_sr = 1;
      if (fire && !go && busy_was_idle) q_tm = 1;
    end
  end

  // idle state of the model before the edge (captured at the preceding negedge)
  bit busy_was_idle = 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    busy_was_idle = (ph == 0);
    if (rst_n) begin
      check("R2", "tap_sel", int'(tap_sel), m_tap());
      check("R6", "busy", int'(busy), (ph != 0) ? 1 : 0);
      check("R5", "pdl_load", int'(pdl_load), (ph == 2) ? 1 : 0);
      check("R3", "pdl_value", int'(pdl_value), res);
      check("R4", "overflow", int'(overflow), ov);
      check("R7", "sr_exit_ack", int'(sr_exit_ack), (ph == 2 && tag) ? 1 : 0);
      if (pdl_load) loads_seen++;
    end
  end

  task automatic pulse_sw();
    @(negedge clk); sw_cal_req = 1'b1;
    @(negedge clk); sw_cal_req = 1'b0;
  endtask

  task automatic pulse_sr();
    @(negedge clk); sr_exit_req = 1'b1;
    @(negedge clk); sr_exit_req = 1'b0;
  endtask

  task automatic settle_idle();
    repeat (8) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    // reset state
    repeat (4) @(negedge clk);
    check("R6", "busy in reset", int'(busy), 0);
    check("R2", "tap in reset", int'(tap_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: calibration runs after reset release without any request
    check("R1", "busy after reset", int'(busy), 1);
    check("R2", "first tap", int'(tap_sel), 1);
    settle_idle();
    check("R3", "count after boot", int'(pdl_value), 10);

    // R8, R3: software request, minimum chain
    target = 1;
    pulse_sw();
    settle_idle();
    check("R3", "count minimum", int'(pdl_value), 1);

    // R3: exactly the last tap
    target = 255;
    pulse_sw();
    settle_idle();
    check("R3", "count last tap", int'(pdl_value), 255);
    check("R4", "no overflow at 255", int'(overflow), 0);

    // R4: chain never reaches a period
    target = 300;
    pulse_sw();
    settle_idle();
    check("R4", "saturated count", int'(pdl_value), 255);
    check("R4", "overflow set", int'(overflow), 1);

    // R7: self-refresh exit with acknowledge
    target = 37;
    pulse_sr();
    settle_idle();
    check("R4", "overflow cleared", int'(overflow), 0);

    // R8: software request during a sweep is queued for one more run
    target = 20;
    pulse_sw();
    repeat (6) @(negedge clk);
    target = 12;
    pulse_sw();
    // R7: exit request during a sweep acknowledged on the following run
    pulse_sr();
    settle_idle();
    check("R8", "queued run count", int'(pdl_value), 12);

    // R9: periodic recalibration
    target = 5;
    loads_seen = 0;
    periodic_interval = 16'd60;
    periodic_en = 1'b1;
    repeat (400) @(negedge clk);
    check("R9", "periodic loads seen", (loads_seen >= 5) ? 1 : 0, 1);
    // R9: expiries while busy are absorbed
    periodic_interval = 16'd3;
    repeat (200) @(negedge clk);
    periodic_interval = 16'd0;
    repeat (100) @(negedge clk);
    periodic_en = 1'b0;
    settle_idle();
    finish_run();
  end

endmodule